// File: doc/BRIEF.md
# Serial Video TRS Word Aligner

This block sits behind the deserializer of a serial digital video receiver. It takes 10-bit parallel words whose bit boundaries are arbitrary and turns them into aligned video words. The recovered bits are treated as one serial stream, least significant bit first. Each bit is first NRZI-decoded with the polynomial x+1 and then descrambled with the self-synchronizing polynomial x^9+x^4+1. The descrambled stream is then searched at all ten bit offsets at once for the timing reference preamble. Output words are cut from the stream at the offset the block has settled on.

Lock uses hysteresis in both directions. The block locks only after three preambles in a row at one offset. Once locked, it moves to a new offset only after two preambles in a row at that same new offset. A rising edge on the switch-line resync input makes the very next preamble move the offset at once. If the aligner stays silent for a parameterised number of words, it drops back to searching. Three mode inputs, together with reset, gate the whole lock mechanism.

Both stream interfaces use valid/ready. Every accepted input word yields exactly one output beat. An output beat is held unchanged while `out_ready` is low, and the input is back-pressured only by a held beat. The lock flag (`aligned`) is a plain status pin.

Top module: `vtrs_word_aligner`

## Requirements
- R1: `in_ready` is high whenever no output beat is held or `out_ready` is high. While `out_valid` is high and `out_ready` low, `out_valid`, `out_data` and `out_trs` stay unchanged.
- R2: Stream bit k (input word n, bit i, k = 10n+i) is decoded as n_k = raw_k XOR raw_(k-1), then d_k = n_k XOR n_(k-4) XOR n_(k-9). Bits before reset count as 0. The output beat for input word n carries d bits 10(n-3)+off up to 10(n-3)+off+9, with the lowest bit in bit 0, where off is the offset in force after that word.
- R3: A preamble at offset o (0..9) of the beat-n window is found when three conditions hold: d bits 10(n-3)+o+2 to +9 are all ones, bits +10 to +29 are all zero, and bits +0 and +1 are ignored, so both 0x3FF and the 0x3FC form match. `out_trs` of that beat is 1, and the lowest matching offset wins.
- R4: While searching, `aligned` rises on the beat of the third consecutive preamble found at one offset. That beat already uses the new offset.
- R5: While searching, a preamble at a different offset restarts the count at one for the new offset.
- R6: While aligned, one preamble at a new offset leaves the offset unchanged. A second consecutive preamble at that same new offset moves the offset on its own beat, and `aligned` stays high.
- R7: While aligned, a preamble at the current offset cancels a pending candidate offset.
- R8: After a rising edge on `switch_resync` while aligned, the next preamble at any offset becomes the offset on its own beat.
- R9: While aligned, TIMEOUT_WORDS consecutive accepted words without a preamble clear `aligned` on the beat of the last of them.
- R10: `asi_mode` high, `video_en` low or `carrier_lost` high clears `aligned` at the next clock edge and discards all progress toward lock.
- R11: After reset, `out_valid`, `out_trs` and `aligned` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 10 | Raw recovered word, earliest bit in bit 0 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 10 | Decoded word cut at the chosen offset |
| out_trs | output | 1 | A preamble was found in this beat's window |
| asi_mode | input | 1 | Asynchronous-serial mode selected; stops video lock |
| video_en | input | 1 | Video path enabled; low stops lock |
| carrier_lost | input | 1 | No input carrier; high stops lock |
| switch_resync | input | 1 | Rising edge requests realignment on the next preamble |
| aligned | output | 1 | Word alignment is locked |

## Verification
Each output beat is registered on the same edge that accepts its input word. `out_data`, `out_trs` and `aligned` for that word are therefore due one edge after acceptance, and the bench samples them on the falling edge that follows. Mode changes and the switch request take effect on that same accepting edge, so the bench applies them together with the word whose beat they must affect. A stall is checked on the three falling edges while `out_ready` is held low: `in_ready` is then low and the beat unchanged. The bench encodes a known plain bit stream into raw words. Its own model of the lock rules then predicts every beat.

// File: rtl/vtrs_pkg.sv
`timescale 1ns/1ps
package vtrs_pkg;
  localparam int WORD_W    = 10;
  localparam int OFF_W     = $clog2(WORD_W);
  localparam int WIN_WORDS = 4;
  localparam int WIN_W     = WIN_WORDS * WORD_W;
  localparam int HIST_W    = WIN_W - WORD_W;
  localparam int TAP_NEAR  = 4;
  localparam int TAP_FAR   = 9;
  localparam int IGN_LSBS  = 2;
  localparam int LOCK_HITS = 3;
  localparam int CNT_W     = $clog2(LOCK_HITS + 1);

  typedef enum logic {ST_SEARCH = 1'b0, ST_LOCKED = 1'b1} align_st_t;
endpackage

// File: rtl/vtrs_descrambler.sv
`timescale 1ns/1ps
module vtrs_descrambler
  import vtrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] plain
);
  logic               last_q, last_d;
  logic [TAP_FAR-1:0] hist_q, hist_d;

  always_comb begin
    logic               rl;
    logic               nb;
    logic [TAP_FAR-1:0] nh;
    rl = last_q;
    nh = hist_q;
    plain = '0;
    for (int i = 0; i < WORD_W; i++) begin
      nb = raw[i] ^ rl;
      rl = raw[i];
      plain[i] = nb ^ nh[TAP_NEAR-1] ^ nh[TAP_FAR-1];
      nh = {nh[TAP_FAR-2:0], nb};
    end
    last_d = rl;
    hist_d = nh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      hist_q <= '0;
    end else if (advance) begin
      last_q <= last_d;
      hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/vtrs_detector.sv
`timescale 1ns/1ps
module vtrs_detector
  import vtrs_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  output logic             hit,
  output logic [OFF_W-1:0] hit_off
);
  logic [WORD_W-1:0] match;

  for (genvar g = 0; g < WORD_W; g++) begin : g_off
    assign match[g] = (&win[g+IGN_LSBS +: WORD_W-IGN_LSBS]) &&
                      (win[g+WORD_W +: 2*WORD_W] == '0);
  end

  always_comb begin
    hit     = |match;
    hit_off = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (match[i]) hit_off = OFF_W'(i);
    end
  end
endmodule

// File: rtl/vtrs_lock_fsm.sv
`timescale 1ns/1ps
module vtrs_lock_fsm
  import vtrs_pkg::*;
#(
  parameter int TIMEOUT_WORDS = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             accept,
  input  logic             hit,
  input  logic [OFF_W-1:0] hit_off,
  input  logic             sw_req,
  output logic             locked,
  output logic [OFF_W-1:0] off_nxt
);
  localparam int TMR_W = $clog2(TIMEOUT_WORDS);

  align_st_t        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [OFF_W-1:0] cand_q, cand_n, off_q, off_n, pend_q, pend_n;
  logic             pend_v_q, pend_v_n, armed_q, armed_n, sw_q;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic             evt, armed_eff;

  assign evt       = accept && hit;
  assign armed_eff = armed_q | (sw_req & ~sw_q);

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; cand_n = cand_q; off_n = off_q;
    pend_n = pend_q; pend_v_n = pend_v_q; armed_n = armed_q; tmr_n = tmr_q;
    if (!enable) begin
      st_n = ST_SEARCH; cnt_n = '0; pend_v_n = 1'b0; armed_n = 1'b0; tmr_n = '0;
    end else if (st_q == ST_SEARCH) begin
      armed_n = 1'b0;
      if (evt) begin
        if (cnt_q != '0 && hit_off == cand_q) begin
          if (cnt_q == CNT_W'(LOCK_HITS - 1)) begin
            st_n = ST_LOCKED; off_n = hit_off; cnt_n = '0; tmr_n = '0; pend_v_n = 1'b0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end else begin
          cand_n = hit_off;
          cnt_n  = CNT_W'(1);
        end
      end
    end else begin
      armed_n = armed_eff;
      if (evt) begin
        tmr_n = '0;
        if (armed_eff) begin
          off_n = hit_off; armed_n = 1'b0; pend_v_n = 1'b0;
        end else if (hit_off == off_q) begin
          pend_v_n = 1'b0;
        end else if (pend_v_q && hit_off == pend_q) begin
          off_n = hit_off; pend_v_n = 1'b0;
        end else begin
          pend_n = hit_off; pend_v_n = 1'b1;
        end
      end else if (accept) begin
        if (tmr_q == TMR_W'(TIMEOUT_WORDS - 1)) begin
          st_n = ST_SEARCH; cnt_n = '0; pend_v_n = 1'b0; armed_n = 1'b0; tmr_n = '0;
        end else begin
          tmr_n = tmr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_SEARCH; cnt_q <= '0; cand_q <= '0; off_q <= '0; pend_q <= '0;
      pend_v_q <= 1'b0; armed_q <= 1'b0; tmr_q <= '0; sw_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; cand_q <= cand_n; off_q <= off_n; pend_q <= pend_n;
      pend_v_q <= pend_v_n; armed_q <= armed_n; tmr_q <= tmr_n; sw_q <= sw_req;
    end
  end

  assign locked  = (st_q == ST_LOCKED);
  assign off_nxt = off_n;

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(accept && hit && enable));

  // R10
  mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !locked);

  // R9
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(!enable || (accept && !hit)));

  // R6
  off_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && off_q != $past(off_q)) |-> $past(accept && hit));
endmodule

// File: rtl/vtrs_word_aligner.sv
`timescale 1ns/1ps
module vtrs_word_aligner
  import vtrs_pkg::*;
#(
  parameter int TIMEOUT_WORDS = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_trs,
  input  logic              asi_mode,
  input  logic              video_en,
  input  logic              carrier_lost,
  input  logic              switch_resync,
  output logic              aligned
);
  logic              accept, enable, hit;
  logic [WORD_W-1:0] plain;
  logic [HIST_W-1:0] hist_q;
  logic [WIN_W-1:0]  win_next;
  logic [OFF_W-1:0]  hit_off, off_nxt;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign enable   = !asi_mode && video_en && !carrier_lost;
  assign win_next = {plain, hist_q};

  vtrs_descrambler u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .raw     (in_data),
    .plain   (plain)
  );

  vtrs_detector u_det (
    .win     (win_next),
    .hit     (hit),
    .hit_off (hit_off)
  );

  vtrs_lock_fsm #(.TIMEOUT_WORDS(TIMEOUT_WORDS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .accept  (accept),
    .hit     (hit),
    .hit_off (hit_off),
    .sw_req  (switch_resync),
    .locked  (aligned),
    .off_nxt (off_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_trs   <= 1'b0;
      hist_q    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= win_next[off_nxt +: WORD_W];
      out_trs   <= hit;
      hist_q    <= win_next[WIN_W-1:WORD_W];
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_trs   <= 1'b0;
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_trs)));
endmodule

// File: tb/sim_vtrs_word_aligner.sv
`timescale 1ns/1ps
module sim_vtrs_word_aligner;
  localparam int TMO  = 40;
  localparam int MAXB = 6000;
  localparam int MAXW = MAXB / 10;

  logic       clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic       asi_mode = 1'b0, video_en = 1'b1, carrier_lost = 1'b0, switch_resync = 1'b0;
  logic [9:0] in_data = '0;
  logic       in_ready, out_valid, out_trs, aligned;
  logic [9:0] out_data;

  always #2.5 clk = ~clk;  // 200 MHz

  vtrs_word_aligner #(.TIMEOUT_WORDS(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_trs(out_trs),
    .asi_mode(asi_mode), .video_en(video_en), .carrier_lost(carrier_lost),
    .switch_resync(switch_resync), .aligned(aligned)
  );

  bit    pbits [MAXB];
  bit    sbits [MAXB];
  bit    asi_v [MAXW];
  bit    ven_v [MAXW];
  bit    cd_v  [MAXW];
  bit    sw_v  [MAXW];
  bit    stall_v [MAXW];
  bit    r_last;
  int    nbits, nwords, fill_seed;
  int    checks = 0, fails = 0;
  string tag;
  bit    m_lk, m_pv, m_arm;
  int    m_cnt, m_cand, m_off, m_pend, m_tmr;

  function automatic bit gb(int b);
    return (b < 0 || b >= MAXB) ? 1'b0 : pbits[b];
  endfunction

  task automatic b_bit(bit v);
    pbits[nbits] = v;
    nbits++;
  endtask

  task automatic b_word(logic [9:0] v);
    for (int i = 0; i < 10; i++) b_bit(v[i]);
  endtask

  task automatic b_junk(int k);
    for (int i = 0; i < k; i++) b_bit(i % 2 == 0);
  endtask

  task automatic b_fill(int k);
    for (int j = 0; j < k; j++) begin
      b_word(10'h100 | 10'((fill_seed * 37) % 256));
      fill_seed++;
    end
  endtask

  task automatic b_line(logic [9:0] first);
    b_word(first); b_word(10'h000); b_word(10'h000); b_word(10'h274);
    b_fill(12);
  endtask

  task automatic b_finish();
    b_fill(3);
    while (nbits % 10 != 0) b_bit(1'b0);
    nwords = nbits / 10;
  endtask

  task automatic encode(int n, output logic [9:0] raw);
    int k; bit s;
    for (int i = 0; i < 10; i++) begin
      k = 10 * n + i;
      s = pbits[k] ^ ((k >= 4) ? sbits[k-4] : 1'b0) ^ ((k >= 9) ? sbits[k-9] : 1'b0);
      sbits[k] = s;
      raw[i] = s ^ r_last;
      r_last = raw[i];
    end
  endtask

  task automatic m_search(int n, output bit h, output int o);
    bit ok; int b;
    h = 1'b0; o = 0;
    for (int c = 9; c >= 0; c--) begin
      ok = 1'b1;
      b = 10 * (n - 3) + c;
      for (int i = 2; i < 10; i++) if (!gb(b + i)) ok = 1'b0;
      for (int i = 10; i < 30; i++) if (gb(b + i)) ok = 1'b0;
      if (ok) begin h = 1'b1; o = c; end
    end
  endtask

  task automatic m_step(int n, bit en, bit rise, output bit h);
    int o; bit ae;
    m_search(n, h, o);
    if (!en) begin
      m_lk = 0; m_cnt = 0; m_pv = 0; m_arm = 0; m_tmr = 0;
    end else if (!m_lk) begin
      m_arm = 0;
      if (h) begin
        if (m_cnt != 0 && o == m_cand) begin
          if (m_cnt == 2) begin m_lk = 1; m_off = o; m_cnt = 0; m_tmr = 0; m_pv = 0; end
          else m_cnt++;
        end else begin
          m_cand = o; m_cnt = 1;
        end
      end
    end else begin
      ae = m_arm | rise;
      m_arm = ae;
      if (h) begin
        m_tmr = 0;
        if (ae) begin m_off = o; m_arm = 0; m_pv = 0; end
        else if (o == m_off) m_pv = 0;
        else if (m_pv && o == m_pend) begin m_off = o; m_pv = 0; end
        else begin m_pend = o; m_pv = 1; end
      end else if (m_tmr == TMO - 1) begin
        m_lk = 0; m_cnt = 0; m_pv = 0; m_arm = 0; m_tmr = 0;
      end else begin
        m_tmr++;
      end
    end
  endtask

  task automatic scen_reset(string t);
    tag = t; nbits = 0; fill_seed = 1; r_last = 1'b0;
    for (int i = 0; i < MAXW; i++) begin
      asi_v[i] = 0; ven_v[i] = 1; cd_v[i] = 0; sw_v[i] = 0; stall_v[i] = 0;
    end
    m_lk = 0; m_pv = 0; m_arm = 0; m_cnt = 0; m_cand = 0; m_off = 0; m_pend = 0; m_tmr = 0;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1; switch_resync = 1'b0;
    asi_mode = 1'b0; video_en = 1'b1; carrier_lost = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_trs !== 1'b0 || aligned !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R11 reset state: valid=%b trs=%b aligned=%b ready=%b exp 0 0 0 1",
               out_valid, out_trs, aligned, in_ready);
    end
  endtask

  task automatic run_stream();
    logic [9:0] prev;
    bit         prev_sw;
    prev_sw = 1'b0;
    for (int n = 0; n < nwords; n++) begin
      logic [9:0] raw;
      logic [9:0] ex;
      bit         h, en, rise;
      encode(n, raw);
      in_valid = 1'b1; in_data = raw;
      asi_mode = asi_v[n]; video_en = ven_v[n]; carrier_lost = cd_v[n];
      switch_resync = sw_v[n];
      if (stall_v[n] && n > 0) begin
        out_ready = 1'b0;
        prev = out_data;
        for (int c = 0; c < 3; c++) begin
          @(negedge clk);
          checks++;
          if (in_ready !== 1'b0 || out_valid !== 1'b1 || out_data !== prev) begin
            fails++;
            $display("FAIL R1 stall: ready=%b valid=%b data=%h exp 0 1 %h",
                     in_ready, out_valid, out_data, prev);
          end
        end
        out_ready = 1'b1;
      end
      en   = !asi_v[n] && ven_v[n] && !cd_v[n];
      rise = sw_v[n] && !prev_sw;
      prev_sw = sw_v[n];
      @(negedge clk);
      m_step(n, en, rise, h);
      for (int i = 0; i < 10; i++) ex[i] = gb(10 * (n - 3) + m_off + i);
      checks++;
      if (out_valid !== 1'b1 || out_data !== ex || out_trs !== h || aligned !== m_lk) begin
        fails++;
        $display("FAIL %s beat %0d: valid=%b data=%h trs=%b aligned=%b exp 1 %h %b %b",
                 tag, n, out_valid, out_data, out_trs, aligned, ex, h, m_lk);
      end
    end
    in_valid = 1'b0; switch_resync = 1'b0;
    asi_mode = 1'b0; video_en = 1'b1; carrier_lost = 1'b0;
    @(negedge clk);
  endtask

  task automatic mode_case(string t, int kind);
    int idx;
    scen_reset(t);
    b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
    idx = nbits / 10;
    for (int i = idx; i < idx + 40; i++) begin
      if (kind == 0) asi_v[i] = 1;
      else if (kind == 1) ven_v[i] = 0;
      else cd_v[i] = 1;
    end
    b_line(10'h3FF); b_line(10'h3FF); b_fill(10);
    b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
    b_finish();
    run_stream();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: got hung run, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    int idx;
    // R2 R4: lock at every bit offset, with stalls at one offset (R1)
    for (int o = 0; o < 10; o++) begin
      scen_reset("R2 R4 sweep");
      b_fill(2); b_junk(o);
      b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
      b_finish();
      if (o == 5) begin stall_v[10] = 1; stall_v[30] = 1; end
      run_stream();
    end
    // R3: eight-bit preamble form, mixed with the full form
    scen_reset("R3 short preamble");
    b_junk(7);
    b_line(10'h3FC); b_line(10'h3FC); b_line(10'h3FC); b_line(10'h3FF);
    b_finish();
    run_stream();
    // R5: offset change while searching restarts the count
    scen_reset("R5 search restart");
    b_junk(2); b_line(10'h3FF); b_line(10'h3FF);
    b_junk(3); b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
    b_finish();
    run_stream();
    // R6 R7: pending offset, cancel, then two in a row
    scen_reset("R6 R7 realign");
    b_junk(4); b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
    b_junk(4); b_line(10'h3FF);
    b_junk(6); b_line(10'h3FF);
    b_junk(4); b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
    b_finish();
    run_stream();
    // R8: switch-line request moves offset on the next preamble
    scen_reset("R8 switch resync");
    b_junk(1); b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
    idx = nbits / 10 + 1;
    sw_v[idx] = 1; sw_v[idx+1] = 1;
    b_fill(3); b_junk(5); b_line(10'h3FF); b_line(10'h3FF);
    b_finish();
    run_stream();
    // R9: silence beyond the timeout drops lock, then relock
    scen_reset("R9 timeout");
    b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
    b_fill(50);
    b_line(10'h3FF); b_line(10'h3FF); b_line(10'h3FF);
    b_finish();
    run_stream();
    // R10: each mode input forces the block out of lock
    mode_case("R10 asi", 0);
    mode_case("R10 video_en", 1);
    mode_case("R10 carrier", 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule